// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block generates the column addresses of a single read or write burst for a double data rate DRAM controller. A programmed mode word supplies a three-bit burst-length code, a burst-order bit and a three-bit read-latency code. An access command supplies a starting column and a read/write flag. When the start strobe is sampled, the block emits one column per clock until the burst completes. Every address stays inside the aligned block of columns whose size equals the burst length. Within that block, the low bits follow either a wrapping upward count or an XOR pattern against the beat index.

The mode word, starting column and direction are captured when the start strobe is sampled, so later changes on those inputs do not disturb a burst already running. A new start during a burst abandons the old burst and begins the new one on the next cycle, which is how burst interruption is modelled. A start that meets a reserved length code produces an error pulse instead of addresses, and it also halts any burst that was running. The latency field is decoded continuously for the neighbouring read-data alignment logic.

Top module: `burst_col_seq`

## Requirements
- R1: The length field `mode_word[2:0]` selects the beat count: 001 gives 2 beats, 010 gives 4 and 011 gives 8. An accepted burst holds `col_valid` high for exactly that many consecutive cycles, one column per cycle.
- R2: With `mode_word[3]` = 0 (sequential), the low log2(BL) bits of beat i equal (start offset + i) modulo BL.
- R3: During a burst, the column bits above the low log2(BL) bits equal those of the starting column on every beat.
- R4: With `mode_word[3]` = 1 (interleaved), the low log2(BL) bits of beat i equal the start offset XOR i.
- R5: The first beat appears in the cycle after the edge that samples `start`, and its column equals `start_col`.
- R6: `done` is high for one cycle, together with `col_valid`, on the final beat only.
- R7: A start sampled while the length field holds a reserved code (000, 100, 101, 110, 111) raises `burst_err` for exactly the following cycle. It produces no beats and ends any burst in progress.
- R8: A valid start sampled during an active burst abandons the remaining beats and emits the new burst's first beat in the next cycle.
- R9: The mode word, starting column and direction are sampled only with `start`. Changes on those inputs during a burst do not alter its columns, its length or `col_wr`.
- R10: `col_wr` carries the `is_write` value sampled with `start` on every beat. Reads and writes use the same programmed length and order.
- R11: The latency field `mode_word[6:4]` is decoded combinationally. 100 gives `lat_clks` = 4 and 101 gives `lat_clks` = 5, each with `lat_ok` = 1. Every other code gives `lat_ok` = 0 and `lat_clks` = 0.
- R12: While `rst_n` is low, and after reset is released, `col_valid`, `done` and `burst_err` are low until a start is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_word | input | 12 | Programmed mode word: length [2:0], order [3], latency [6:4] |
| start | input | 1 | Start a burst from `start_col` |
| start_col | input | 9 | Starting column of the access |
| is_write | input | 1 | Direction of the access, 1 for write |
| col_valid | output | 1 | A column beat is presented |
| col_addr | output | 9 | Column for the current beat |
| col_wr | output | 1 | Direction of the current burst |
| done | output | 1 | Final beat of the burst |
| burst_err | output | 1 | A start met a reserved length code |
| lat_ok | output | 1 | The latency field holds a supported code |
| lat_clks | output | 3 | Decoded read latency in clocks |

## Verification
The hardest situations to create from the ports are those where a burst is cut short. One is a valid restart that lands mid-burst. The other is a reserved-length start that arrives while beats are still flowing. In both cases the outstanding columns of the old burst must vanish in exactly the right cycle. The driver raises `start` again while the previous burst is still being emitted, then flushes the scoreboard queue at the sampling edge. Any leftover or early beat therefore appears as an unexpected or mismatched item. The mode word and starting column are also changed in the middle of a burst, which shows that only the values captured at start take effect.

// File: rtl/bcs_pkg.sv
// Package: shared field positions and decode helpers for the burst
// column sequencer. Assumes a mode word with length in [2:0],
// order bit at [3] and latency code in [6:4].
package bcs_pkg;

    localparam int LEN_LSB  = 0;
    localparam int ORD_POS  = 3;
    localparam int LAT_LSB  = 4;
    localparam int FIELD_W  = 3;
    localparam int MAX_LG   = 3;   // longest burst is 2**MAX_LG beats

    typedef struct packed {
        logic       ok;
        logic [1:0] lg;            // log2 of the beat count
    } len_dec_t;

    typedef struct packed {
        logic       ok;
        logic [2:0] clks;
    } lat_dec_t;

    // Map a length code to its log2 beat count; reserved codes give ok=0.
    function automatic len_dec_t decode_len(input logic [FIELD_W-1:0] code);
        len_dec_t r;
        case (code)
            3'b001:  r = '{ok: 1'b1, lg: 2'd1};
            3'b010:  r = '{ok: 1'b1, lg: 2'd2};
            3'b011:  r = '{ok: 1'b1, lg: 2'd3};
            default: r = '{ok: 1'b0, lg: 2'd0};
        endcase
        return r;
    endfunction

    // Map a latency code to a clock count; reserved codes give ok=0.
    function automatic lat_dec_t decode_lat(input logic [FIELD_W-1:0] code);
        lat_dec_t r;
        case (code)
            3'b100:  r = '{ok: 1'b1, clks: 3'd4};
            3'b101:  r = '{ok: 1'b1, clks: 3'd5};
            default: r = '{ok: 1'b0, clks: 3'd0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bcs_mode_decode.sv
// Mode decoder: splits the programmed mode word into burst length,
// burst order and read latency. Purely combinational; assumes the
// word is held stable by its owner between programming events.
module bcs_mode_decode
    import bcs_pkg::*;
#(
    parameter int MODE_W = 12
) (
    input  logic [MODE_W-1:0] mode_word,
    output logic              len_ok,
    output logic [1:0]        len_lg,
    output logic              interleave,
    output logic              lat_ok,
    output logic [2:0]        lat_clks
);

    len_dec_t len_d;
    lat_dec_t lat_d;

    // Field extraction and table lookup.
    always_comb begin
        len_d      = decode_len(mode_word[LEN_LSB +: FIELD_W]);
        lat_d      = decode_lat(mode_word[LAT_LSB +: FIELD_W]);
        len_ok     = len_d.ok;
        len_lg     = len_d.lg;
        interleave = mode_word[ORD_POS];
        lat_ok     = lat_d.ok;
        lat_clks   = lat_d.clks;
    end

endmodule

// File: rtl/bcs_burst_ctl.sv
// Burst controller: captures the access on start, counts beats and
// flags the final one. A start with a reserved length is refused with
// a one-cycle error and stops any running burst. Assumes start is a
// single-cycle strobe from the command path.
module bcs_burst_ctl
    import bcs_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic              is_write,
    input  logic              len_ok,
    input  logic [1:0]        len_lg,
    input  logic              interleave,
    output logic              active,
    output logic [MAX_LG-1:0] beat,
    output logic [1:0]        lg_q,
    output logic              inter_q,
    output logic [COL_W-1:0]  base_q,
    output logic              wr_q,
    output logic              last,
    output logic              err_q
);

    logic [MAX_LG-1:0] beat_end;

    // Index of the final beat for the captured length.
    always_comb begin
        beat_end = MAX_LG'((1 << lg_q) - 1);
        last     = active && (beat == beat_end);
    end

    // Capture on start, advance the beat index, end on the final beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            beat    <= '0;
            lg_q    <= 2'd0;
            inter_q <= 1'b0;
            base_q  <= '0;
            wr_q    <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            err_q <= 1'b0;
            if (start) begin
                if (len_ok) begin
                    active  <= 1'b1;
                    beat    <= '0;
                    lg_q    <= len_lg;
                    inter_q <= interleave;
                    base_q  <= start_col;
                    wr_q    <= is_write;
                end else begin
                    active <= 1'b0;
                    beat   <= '0;
                    err_q  <= 1'b1;
                end
            end else if (active) begin
                if (last) begin
                    active <= 1'b0;
                    beat   <= '0;
                end else begin
                    beat <= beat + 1'b1;
                end
            end
        end
    end

    // R7: a refused start leaves no burst running.
    p_err_ends_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> !active);

    // R1: the beat index never passes the captured burst length.
    p_beat_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (beat <= beat_end));

endmodule

// File: rtl/bcs_addr_gen.sv
// Address generator: forms the column of the current beat. Bits above
// the burst block come from the captured column; the low bits follow
// the sequential (wrapping add) or interleaved (XOR) order. Assumes
// COL_W exceeds the widest offset.
module bcs_addr_gen
    import bcs_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0]  base,
    input  logic [MAX_LG-1:0] beat,
    input  logic [1:0]        lg,
    input  logic              inter,
    output logic [COL_W-1:0]  addr
);

    localparam int OFF_W = MAX_LG;

    logic [OFF_W-1:0] low_seq;
    logic [OFF_W-1:0] low_int;
    logic [OFF_W-1:0] low_sel;

    // Candidate offsets for both orders.
    always_comb begin
        low_seq = base[OFF_W-1:0] + beat;
        low_int = base[OFF_W-1:0] ^ beat;
        low_sel = inter ? low_int : low_seq;
    end

    // Per offset bit: inside the block take the ordered value, else hold.
    for (genvar i = 0; i < OFF_W; i++) begin : g_off
        assign addr[i] = ({1'b0, lg} > 3'(i)) ? low_sel[i] : base[i];
    end

    assign addr[COL_W-1:OFF_W] = base[COL_W-1:OFF_W];

endmodule

// File: rtl/burst_col_seq.sv
// Top of the burst column sequencer: decodes the mode word, runs the
// beat controller and presents one column per clock with a done
// pulse on the last beat. Assumes a synchronous active-low reset.
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int MODE_W = 12,
    parameter int COL_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic              is_write,
    output logic              col_valid,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_wr,
    output logic              done,
    output logic              burst_err,
    output logic              lat_ok,
    output logic [2:0]        lat_clks
);

    logic              len_ok;
    logic [1:0]        len_lg;
    logic              interleave;
    logic              active;
    logic [MAX_LG-1:0] beat;
    logic [1:0]        lg_q;
    logic              inter_q;
    logic [COL_W-1:0]  base_q;
    logic              wr_q;
    logic              last;
    logic              err_q;
    logic [MAX_LG-1:0] off_mask;

    bcs_mode_decode #(.MODE_W(MODE_W)) u_dec (
        .mode_word  (mode_word),
        .len_ok     (len_ok),
        .len_lg     (len_lg),
        .interleave (interleave),
        .lat_ok     (lat_ok),
        .lat_clks   (lat_clks)
    );

    bcs_burst_ctl #(.COL_W(COL_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_col  (start_col),
        .is_write   (is_write),
        .len_ok     (len_ok),
        .len_lg     (len_lg),
        .interleave (interleave),
        .active     (active),
        .beat       (beat),
        .lg_q       (lg_q),
        .inter_q    (inter_q),
        .base_q     (base_q),
        .wr_q       (wr_q),
        .last       (last),
        .err_q      (err_q)
    );

    bcs_addr_gen #(.COL_W(COL_W)) u_gen (
        .base  (base_q),
        .beat  (beat),
        .lg    (lg_q),
        .inter (inter_q),
        .addr  (col_addr)
    );

    // Output strobes straight from controller state.
    always_comb begin
        col_valid = active;
        col_wr    = wr_q;
        done      = last;
        burst_err = err_q;
        off_mask  = MAX_LG'((1 << lg_q) - 1);
    end

    // R5: the first beat follows an accepted start and carries its column.
    p_first_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(start) && $past(len_ok)) |->
        (col_valid && col_addr == $past(start_col)));

    // R3: block bits above the widest offset hold across a burst.
    p_upper_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && $past(col_valid) && !$past(start)) |->
        (col_addr[COL_W-1:MAX_LG] == $past(col_addr[COL_W-1:MAX_LG])));

    // R2: in sequential order the offset steps by one, modulo the length.
    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && $past(col_valid) && !$past(start) && !inter_q) |->
        (((col_addr[MAX_LG-1:0] - $past(col_addr[MAX_LG-1:0])) & off_mask)
            == (MAX_LG'(1) & off_mask)));

    // R6: done never lasts two cycles and only comes with a beat.
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> col_valid);

    // R7: an error cycle carries no beat.
    p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        burst_err |-> !col_valid);

endmodule

// File: tb/sim_burst_col_seq.sv
// Scoreboard bench: the driver queues expected beats, the monitor
// compares them against the design at each falling edge.
module sim_burst_col_seq;

    localparam int MODE_W = 12;
    localparam int COL_W  = 9;

    typedef struct {
        logic [COL_W-1:0] addr;
        logic             done;
        logic             wr;
        string            tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [MODE_W-1:0] mode_word = '0;
    logic              start = 1'b0;
    logic [COL_W-1:0]  start_col = '0;
    logic              is_write = 1'b0;
    logic              col_valid;
    logic [COL_W-1:0]  col_addr;
    logic              col_wr;
    logic              done;
    logic              burst_err;
    logic              lat_ok;
    logic [2:0]        lat_clks;

    int n_chk = 0;
    int n_bad = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    burst_col_seq #(.MODE_W(MODE_W), .COL_W(COL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .start(start),
        .start_col(start_col), .is_write(is_write), .col_valid(col_valid),
        .col_addr(col_addr), .col_wr(col_wr), .done(done),
        .burst_err(burst_err), .lat_ok(lat_ok), .lat_clks(lat_clks)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [MODE_W-1:0] mk_mode(input logic [2:0] len, input bit intlv, input logic [2:0] lat);
        return {5'b0, lat, intlv, len};
    endfunction

    // Expected column of beat i from the requirements (R2, R3, R4).
    function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] col, input int lg, input bit intlv, input int i);
        int mask = (1 << lg) - 1;
        int low  = intlv ? (int'(col) ^ i) : (int'(col) + i);
        return COL_W'((int'(col) & ~mask) | (low & mask));
    endfunction

    // Drive one start; flush the queue at the sampling edge and push the new burst.
    task automatic issue(input logic [COL_W-1:0] col, input logic [2:0] len, input bit intlv, input bit wr, input string tag);
        int lg;
        @(posedge clk); #1;
        mode_word = mk_mode(len, intlv, 3'b100);
        start_col = col;
        is_write  = wr;
        start     = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        q.delete();
        lg = (len == 3'b001) ? 1 : (len == 3'b010) ? 2 : (len == 3'b011) ? 3 : 0;
        for (int i = 0; i < (1 << lg) && lg != 0; i++) begin
            exp_t e;
            e.addr = exp_col(col, lg, intlv, i);
            e.done = (i == (1 << lg) - 1);
            e.wr   = wr;
            e.tag  = tag;
            q.push_back(e);
        end
    endtask

    // Wait for the queued beats, then confirm the burst has ended (R1).
    task automatic drain(input string tag);
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
        check(col_valid == 1'b0, {tag, " R1 end"}, col_valid, 0);
        check(done == 1'b0, {tag, " R6 end"}, done, 0);
    endtask

    // Monitor: compare every presented beat against the queue head.
    always @(negedge clk) begin
        if (rst_n && col_valid) begin
            if (q.size() == 0) begin
                check(1'b0, "R8 unexpected beat", col_addr, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(col_addr == e.addr, {e.tag, " addr"}, col_addr, e.addr);
                check(done == e.done, {e.tag, " R6 done"}, done, e.done);
                check(col_wr == e.wr, {e.tag, " R10 wr"}, col_wr, e.wr);
            end
        end else if (rst_n && done) begin
            check(1'b0, "R6 done without beat", done, 0);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(col_valid == 0 && done == 0 && burst_err == 0, "R12 in reset",
              {col_valid, done, burst_err}, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(col_valid == 0 && done == 0 && burst_err == 0, "R12 after reset",
              {col_valid, done, burst_err}, 0);

        // R2 R3 sequential bursts of each length
        issue(9'h1F5, 3'b010, 1'b0, 1'b0, "R2 BL4 seq"); drain("R2");
        issue(9'h0C6, 3'b011, 1'b0, 1'b1, "R2 BL8 seq wr"); drain("R3");
        issue(9'h033, 3'b001, 1'b0, 1'b0, "R1 BL2 seq"); drain("R1");
        // R4 interleaved bursts
        issue(9'h0AD, 3'b011, 1'b1, 1'b0, "R4 BL8 intlv"); drain("R4");
        issue(9'h127, 3'b010, 1'b1, 1'b1, "R4 BL4 intlv wr"); drain("R4b");
        issue(9'h0FF, 3'b001, 1'b1, 1'b0, "R4 BL2 intlv"); drain("R4c");

        // R8 restart mid-burst
        issue(9'h010, 3'b011, 1'b0, 1'b0, "R8 old");
        issue(9'h1EB, 3'b010, 1'b1, 1'b1, "R8 new"); drain("R8");

        // R9 inputs changed during a burst are ignored
        issue(9'h05E, 3'b011, 1'b1, 1'b1, "R9 held");
        @(posedge clk); #1;
        mode_word = mk_mode(3'b001, 1'b0, 3'b101);
        start_col = 9'h1A1;
        is_write  = 1'b0;
        drain("R9");

        // R7 reserved codes, idle and during a burst
        issue(9'h040, 3'b000, 1'b0, 1'b0, "R7 idle");
        @(negedge clk);
        check(burst_err == 1'b1, "R7 err pulse", burst_err, 1);
        check(col_valid == 1'b0, "R7 no beat", col_valid, 0);
        @(negedge clk);
        check(burst_err == 1'b0, "R7 err one cycle", burst_err, 0);
        issue(9'h088, 3'b011, 1'b0, 1'b0, "R7 victim");
        issue(9'h090, 3'b110, 1'b0, 1'b0, "R7 abort");
        @(negedge clk);
        check(burst_err == 1'b1, "R7 err in burst", burst_err, 1);
        check(col_valid == 1'b0, "R7 burst ended", col_valid, 0);
        repeat (3) @(negedge clk);
        check(col_valid == 1'b0, "R7 stays ended", col_valid, 0);

        // R11 latency decode over every code
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            mode_word = mk_mode(3'b010, 1'b0, 3'(c));
            #1;
            check(lat_ok == (c == 4 || c == 5), "R11 lat_ok", lat_ok, (c == 4 || c == 5));
            check(lat_clks == ((c == 4) ? 3'd4 : (c == 5) ? 3'd5 : 3'd0), "R11 lat_clks",
                  lat_clks, (c == 4) ? 4 : (c == 5) ? 5 : 0);
        end

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule